// File: doc/BRIEF.md
# Memory Request Priority Escalation Controller

This block drives the request lines that a buffer-pool engine presents to two shared memories, a packet memory and a control memory. Each memory has its own request channel. A channel takes a pending request from the engine, raises it on either a normal-priority or a high-priority line, and keeps it there until the memory's arbiter grants it. Each channel has at most one request outstanding.

A request is moved to high priority in one of three ways, and each can be enabled for each channel. The first raises every request at high priority. The second, for the packet channel only, raises high priority while the local free-buffer FIFO or get-buffer FIFO is full. The third is a wait timer that goes high once the request has gone unserved for longer than a programmable timeout. When several are enabled, their results are ORed. A request that has reached high priority stays there until it is granted. The next request starts again at normal priority.

Two hold conditions keep the channels from starting new requests. Diagnostic mode holds them idle. A lock-on-error bit, combined with a mask over an error vector, latches a hold that lasts until the bit is cleared. Neither hold withdraws a request that is already outstanding.

Top module: `mem_req_escalator`

## Requirements
- R1: With `pkt_always_hi` set, every packet-memory request is raised on `pkt_req_hi` from its first cycle, and `pkt_req_lo` stays low.
- R2: With `ctl_always_hi` set, every control-memory request is raised on `ctl_req_hi` from its first cycle, and `ctl_req_lo` stays low.
- R3: With `pkt_fifo_hi_en` set, a packet request is on `pkt_req_hi` in any cycle after an edge where `free_fifo_full` or `get_fifo_full` was high. The FIFO flags never affect the control channel.
- R4: With a channel's timer enable set and timeout T loaded when its request is accepted, the request is on the normal line for cycles 0..T of waiting and on the high line from cycle T+1. Cycle 0 is the first cycle the request is visible. Each channel uses its own enable and timeout.
- R5: While `diag_hold` is high, an idle channel accepts no request and both its lines stay low. A request already outstanding stays on its line until granted, and the channel then stays idle.
- R6: When `lock_on_err` is high and any bit of `err_vec & lock_mask` is high, the channels are held as in R5 until `lock_on_err` is cleared, even if the error goes away. Errors on unmasked bits have no effect.
- R7: Once a request is on the high line, it stays there until its grant. The next request on that channel starts on the normal line unless a cause is active.
- R8: At most one of a channel's two request lines is high in any cycle. With no cause enabled, requests use the normal line only.
- R9: A request pending while the channel is idle and not held appears on the next cycle. A grant while the request is visible drops both lines on the next cycle. After reset all four request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_pend | input | 1 | Engine has a packet-memory request pending |
| pkt_gnt | input | 1 | Packet-memory arbiter grant |
| ctl_pend | input | 1 | Engine has a control-memory request pending |
| ctl_gnt | input | 1 | Control-memory arbiter grant |
| pkt_always_hi | input | 1 | Packet requests always high priority |
| ctl_always_hi | input | 1 | Control requests always high priority |
| pkt_fifo_hi_en | input | 1 | Escalate packet requests on a full FIFO |
| free_fifo_full | input | 1 | Free-buffer FIFO full flag |
| get_fifo_full | input | 1 | Get-buffer FIFO full flag |
| pkt_timer_en | input | 1 | Packet wait-timer escalation enable |
| ctl_timer_en | input | 1 | Control wait-timer escalation enable |
| pkt_timeout | input | TMR_W | Packet wait timeout |
| ctl_timeout | input | TMR_W | Control wait timeout |
| diag_hold | input | 1 | Diagnostic mode hold |
| lock_on_err | input | 1 | Lock-on-error enable |
| lock_mask | input | ERR_W | Selects which error bits lock |
| err_vec | input | ERR_W | Error conditions |
| pkt_req_lo | output | 1 | Packet request, normal priority |
| pkt_req_hi | output | 1 | Packet request, high priority |
| ctl_req_lo | output | 1 | Control request, normal priority |
| ctl_req_hi | output | 1 | Control request, high priority |

## Verification
The hardest case to reach from the ports is a request that escalates on a short-lived cause and must then stay high after the cause is gone. The bench starts a packet request with every cause off, pulses the free-FIFO flag for a single cycle partway through the wait, and checks the high line both after the pulse and several cycles later, before the grant. The timer boundary needs the same care. Vectors sample exactly at wait cycle T and at T+1, so an off-by-one in the load or the decrement shows up. The lock latch is tested by clearing the error before the request arrives, so a design that only looks at the error in the current cycle would let the request through.

// File: rtl/mem_req_escalator.sv
module mem_req_escalator #(
  parameter int TMR_W = 8,
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_pend,
  input  logic             pkt_gnt,
  input  logic             ctl_pend,
  input  logic             ctl_gnt,
  input  logic             pkt_always_hi,
  input  logic             ctl_always_hi,
  input  logic             pkt_fifo_hi_en,
  input  logic             free_fifo_full,
  input  logic             get_fifo_full,
  input  logic             pkt_timer_en,
  input  logic             ctl_timer_en,
  input  logic [TMR_W-1:0] pkt_timeout,
  input  logic [TMR_W-1:0] ctl_timeout,
  input  logic             diag_hold,
  input  logic             lock_on_err,
  input  logic [ERR_W-1:0] lock_mask,
  input  logic [ERR_W-1:0] err_vec,
  output logic             pkt_req_lo,
  output logic             pkt_req_hi,
  output logic             ctl_req_lo,
  output logic             ctl_req_hi
);
  localparam int NCH = 2;

  logic             lock_r;
  logic             lock_hit;
  logic             hold;
  logic [NCH-1:0]   pend, gnt, alw, ten, busy, hi;
  logic [NCH-1:0]   instant;
  logic [TMR_W-1:0] tmo [NCH];

  assign lock_hit = lock_on_err && |(lock_mask & err_vec);
  assign hold     = diag_hold || lock_r || lock_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || !lock_on_err) lock_r <= 1'b0;
    else if (lock_hit)          lock_r <= 1'b1;
  end

  assign pend    = {ctl_pend, pkt_pend};
  assign gnt     = {ctl_gnt, pkt_gnt};
  assign alw     = {ctl_always_hi, pkt_always_hi};
  assign ten     = {ctl_timer_en, pkt_timer_en};
  assign tmo[0]  = pkt_timeout;
  assign tmo[1]  = ctl_timeout;
  assign instant = {ctl_always_hi,
                    pkt_always_hi | (pkt_fifo_hi_en & (free_fifo_full | get_fifo_full))};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [TMR_W-1:0] cnt;
    logic             expired;

    assign expired = ten[c] && (cnt == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[c] <= 1'b0;
        hi[c]   <= 1'b0;
        cnt     <= '0;
      end else if (!busy[c]) begin
        if (pend[c] && !hold) begin
          busy[c] <= 1'b1;
          hi[c]   <= instant[c];
          cnt     <= tmo[c];
        end
      end else if (gnt[c]) begin
        busy[c] <= 1'b0;
        hi[c]   <= 1'b0;
      end else begin
        hi[c] <= hi[c] | instant[c] | expired;
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
    end

    // R1 / R2: always-high bit forces the high line on the next cycle
    p_always_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
      alw[c] && ((busy[c] && !gnt[c]) || (!busy[c] && pend[c] && !hold)) |=> hi[c] && busy[c]);

    // R4: an expired timer escalates the waiting request
    p_timer_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy[c] && !gnt[c] && expired |=> hi[c]);

    // R5: a held idle channel stays idle
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[c] && hold |=> !busy[c]);

    // R7: high priority is sticky until grant
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy[c] && hi[c] && !gnt[c] |=> busy[c] && hi[c]);

    // R9: grant retires the request
    p_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy[c] && gnt[c] |=> !busy[c] && !hi[c]);
  end

  assign pkt_req_lo = busy[0] && !hi[0];
  assign pkt_req_hi = busy[0] &&  hi[0];
  assign ctl_req_lo = busy[1] && !hi[1];
  assign ctl_req_hi = busy[1] &&  hi[1];

  // R8: the two lines of a channel are exclusive
  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pkt_req_lo, pkt_req_hi}) && $onehot0({ctl_req_lo, ctl_req_hi}));

  // R3: a full FIFO with escalation enabled raises the packet line
  p_fifo_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_fifo_hi_en && (free_fifo_full || get_fifo_full) && pkt_req_lo && !pkt_gnt |=> pkt_req_hi);

  // R6: a locking error holds the channels while the lock bit stays set
  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hit && lock_on_err && !busy[0] && $stable(lock_on_err) |=> !busy[0] || !lock_on_err);
endmodule

// File: tb/tb_mem_req_escalator.sv
module tb_mem_req_escalator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_pend = 0, pkt_gnt = 0, ctl_pend = 0, ctl_gnt = 0;
  logic pkt_always_hi = 0, ctl_always_hi = 0, pkt_fifo_hi_en = 0;
  logic free_fifo_full = 0, get_fifo_full = 0, pkt_timer_en = 0, ctl_timer_en = 0;
  logic [7:0] pkt_timeout = 0, ctl_timeout = 0;
  logic diag_hold = 0, lock_on_err = 0;
  logic [3:0] lock_mask = 0, err_vec = 0;
  logic pkt_req_lo, pkt_req_hi, ctl_req_lo, ctl_req_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mem_req_escalator dut (.*);

  typedef struct packed {
    logic       ctl;
    logic       alw;
    logic       ffree;
    logic       fget;
    logic       ffen;
    logic       ten;
    logic [3:0] tmo;
    logic [3:0] wt;
    logic       e0;
    logic       ew;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,0,0,0,4'd0,4'd5,0,0,4'd8},  // R8 no cause
    '{0,1,0,0,0,0,4'd0,4'd3,1,1,4'd1},  // R1
    '{1,1,0,0,0,0,4'd0,4'd2,1,1,4'd2},  // R2
    '{0,0,1,0,1,0,4'd0,4'd2,1,1,4'd3},  // R3 free full
    '{0,0,0,1,1,0,4'd0,4'd2,1,1,4'd3},  // R3 get full
    '{0,0,0,0,0,1,4'd3,4'd3,0,0,4'd4},  // R4 boundary T
    '{0,0,0,0,0,1,4'd3,4'd4,0,1,4'd4},  // R4 boundary T+1
    '{1,0,0,0,0,1,4'd2,4'd3,0,1,4'd4},  // R4 control timer
    '{1,0,0,0,0,1,4'd0,4'd1,0,1,4'd4},  // R4 zero timeout
    '{1,0,1,1,1,0,4'd0,4'd2,0,0,4'd3},  // R3 FIFO flags ignored by control
    '{0,0,1,0,0,0,4'd0,4'd2,0,0,4'd3}   // R3 FIFO full without enable
  };

  task automatic chk(input string rq, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {lo,hi} actual=%b expected=%b at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] pk(); return {pkt_req_lo, pkt_req_hi}; endfunction
  function automatic logic [1:0] ck(); return {ctl_req_lo, ctl_req_hi}; endfunction

  task automatic grant(input logic ch);
    if (ch) ctl_gnt = 1; else pkt_gnt = 1;
    @(negedge clk);
    ctl_gnt = 0; pkt_gnt = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset pkt", pk(), 2'b00);
    chk("R9 reset ctl", ck(), 2'b00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VEC[i];
      automatic string tag = $sformatf("R%0d vec%0d", v.rq, i);
      if (v.ctl) begin ctl_always_hi = v.alw; ctl_timer_en = v.ten; ctl_timeout = {4'd0, v.tmo}; end
      else       begin pkt_always_hi = v.alw; pkt_timer_en = v.ten; pkt_timeout = {4'd0, v.tmo}; end
      free_fifo_full = v.ffree; get_fifo_full = v.fget; pkt_fifo_hi_en = v.ffen;
      if (v.ctl) ctl_pend = 1; else pkt_pend = 1;
      @(negedge clk);
      pkt_pend = 0; ctl_pend = 0;
      chk(tag, v.ctl ? ck() : pk(), {~v.e0, v.e0});
      repeat (int'(v.wt)) @(negedge clk);
      chk(tag, v.ctl ? ck() : pk(), {~v.ew, v.ew});
      grant(v.ctl);
      chk({tag, " R9 release"}, v.ctl ? ck() : pk(), 2'b00);
      pkt_always_hi = 0; ctl_always_hi = 0; pkt_timer_en = 0; ctl_timer_en = 0;
      free_fifo_full = 0; get_fifo_full = 0; pkt_fifo_hi_en = 0;
      @(negedge clk);
    end

    // R7: one-cycle FIFO pulse escalates and the escalation sticks
    pkt_fifo_hi_en = 1;
    pkt_pend = 1; @(negedge clk); pkt_pend = 0;
    chk("R7 start normal", pk(), 2'b10);
    free_fifo_full = 1; @(negedge clk); free_fifo_full = 0;
    chk("R7 escalated", pk(), 2'b01);
    repeat (4) @(negedge clk);
    chk("R7 still high", pk(), 2'b01);
    grant(0);
    pkt_pend = 1; @(negedge clk); pkt_pend = 0;
    chk("R7 next request normal", pk(), 2'b10);
    grant(0);
    pkt_fifo_hi_en = 0;

    // R5: diag hold from idle, then while active
    diag_hold = 1; pkt_pend = 1;
    repeat (3) @(negedge clk);
    chk("R5 held idle", pk(), 2'b00);
    diag_hold = 0; @(negedge clk);
    chk("R5 released", pk(), 2'b10);
    diag_hold = 1;
    repeat (2) @(negedge clk);
    chk("R5 active finishes", pk(), 2'b10);
    grant(0);
    @(negedge clk);
    chk("R5 idle after grant", pk(), 2'b00);
    diag_hold = 0; pkt_pend = 0;
    @(negedge clk);
    grant(0);

    // R6: masked error locks until bit cleared
    lock_on_err = 1; lock_mask = 4'b0001; err_vec = 4'b0001;
    @(negedge clk); err_vec = 0;
    ctl_pend = 1;
    repeat (3) @(negedge clk);
    chk("R6 lock holds", ck(), 2'b00);
    lock_on_err = 0;
    repeat (3) @(negedge clk);
    chk("R6 lock cleared", ck(), 2'b10);
    ctl_pend = 0; grant(1);
    // R6: unmasked error has no effect
    lock_on_err = 1; err_vec = 4'b0010; ctl_pend = 1;
    @(negedge clk); ctl_pend = 0;
    chk("R6 unmasked ignored", ck(), 2'b10);
    grant(1);
    lock_on_err = 0; err_vec = 0;

    // R9: grant while idle is ignored
    pkt_gnt = 1; @(negedge clk); pkt_gnt = 0;
    chk("R9 stray grant", pk(), 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule